// File: doc/BRIEF.md
# Synthesizer Clock Output Router

This block is the digital back end of a one-time-programmed frequency synthesizer. It receives two running clocks: the reference from the oscillator and the VCO clock from the analog loop. It divides them with a 5-bit post-divider and routes the results to a primary clock output and an optional secondary clock output. The fused settings appear as static configuration inputs. There are two complete configuration sets. Each set holds a post-divider value, a primary source choice, and the reference and feedback divider values that the block passes to the analog loop.

A single multifunction pin is given one of four roles by configuration:
- an output-enable input,
- a power-down input,
- a set-select input,
- the secondary clock output.

On the board the pin has a pull-up. When nothing drives it in an input role, the block runs normally with set A. Set-select and power-down levels cross into each clock domain through a two-flop synchronizer before they act on a divider. This keeps runt pulses off the outputs.

Top module: `synth_clk_router`

## Requirements
- R1: The post-divider output has a period of 2*P source clock periods, where P is the selected set's 5-bit value. P = 0 behaves exactly like P = 1.
- R2: The primary source code selects the output:
  - 0: VCO/(2P)
  - 1: raw reference
  - 2: reference/(2P)
  - 3: reserved, behaves as 0
- R3: In secondary-clock pin mode (mode code 3), clk1_oe is high. The secondary source code selects clk1_out:
  - 0: reference
  - 1: reference/2
  - 2: the primary clock
  - 3: the primary clock divided by 2
- R4: In the three input pin modes, clk1_oe and clk1_out stay low.
- R5: In output-enable mode (mode code 0), a low pin drives clk0_oe low and a high pin drives it high. In every other mode clk0_oe is high.
- R6: In power-down mode (mode code 1), a low pin forces clk0_out and clk1_out low and holds every divider in reset. After the pin returns high, the outputs resume with the correct period.
- R7: In set-select mode (mode code 2), a high pin selects set A and a low pin selects set B. The selection covers P, the primary source, and the loop divider values.
- R8: In every mode other than set-select, set A is used whatever the pin level.
- R9: loop_r_div and loop_m_div present the 8-bit reference divider and the 11-bit feedback divider of the selected set.
- R10: While rst_n is low, with a divided primary source, clk0_out and clk1_out are low and clk1_oe is low in output-enable mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock from the oscillator |
| clk_vco | input | 1 | VCO clock from the analog loop |
| rst_n | input | 1 | Synchronous active-low reset, held across edges of both clocks |
| cfg_pin_mode | input | 2 | Multifunction pin role: 0 enable, 1 power-down, 2 set-select, 3 secondary clock |
| cfg_clk1_src | input | 2 | Secondary output source code |
| cfg_a_p | input | 5 | Set A post-divider value |
| cfg_a_src | input | 2 | Set A primary source code |
| cfg_a_r | input | 8 | Set A reference divider value |
| cfg_a_m | input | 11 | Set A feedback divider value |
| cfg_b_p | input | 5 | Set B post-divider value |
| cfg_b_src | input | 2 | Set B primary source code |
| cfg_b_r | input | 8 | Set B reference divider value |
| cfg_b_m | input | 11 | Set B feedback divider value |
| mfp_in | input | 1 | Level seen on the multifunction pin (pull-up high when undriven) |
| clk0_out | output | 1 | Primary clock |
| clk0_oe | output | 1 | Primary output driver enable |
| clk1_out | output | 1 | Secondary clock, driven onto the multifunction pin |
| clk1_oe | output | 1 | Driver enable for the multifunction pin |
| loop_r_div | output | 8 | Reference divider value for the analog loop |
| loop_m_div | output | 11 | Feedback divider value for the analog loop |

## Verification
The bench measures the spacing of rising edges on each output. From that spacing it tells apart:
- a missing doubling in the divider,
- an off-by-one terminal count,
- a wrong source routing.

It covers P at 0, 1 and 31, every source code of both outputs, and randomly drawn P and source pairs on either set. Toggling the pin level in set-select mode distinguishes set A from set B through both the output period and the loop divider values. Repeating the toggle in the other modes shows that the pin does not change the set there. Sampling during power-down shows the outputs held low, and the period measured after release shows a clean restart.

// File: rtl/synth_clk_pkg.sv
`timescale 1ns/1ps
// Shared widths, codes and the configuration-set record for the clock router.
// Assumes the fused configuration is static while clocks run.
package synth_clk_pkg;
    parameter int P_W = 5;   // post-divider value width
    parameter int R_W = 8;   // reference divider width
    parameter int M_W = 11;  // feedback divider width

    typedef enum logic [1:0] {
        PIN_ENABLE = 2'd0,
        PIN_PWRDN  = 2'd1,
        PIN_SETSEL = 2'd2,
        PIN_CLKOUT = 2'd3
    } pin_mode_e;

    typedef enum logic [1:0] {
        SRC0_LOOP   = 2'd0,
        SRC0_REF    = 2'd1,
        SRC0_REFDIV = 2'd2,
        SRC0_RSVD   = 2'd3
    } clk0_src_e;

    typedef enum logic [1:0] {
        SRC1_REF    = 2'd0,
        SRC1_REF2   = 2'd1,
        SRC1_CLK0   = 2'd2,
        SRC1_CLK0H  = 2'd3
    } clk1_src_e;

    typedef struct packed {
        logic [P_W-1:0] p;
        clk0_src_e      src;
        logic [R_W-1:0] r;
        logic [M_W-1:0] m;
    } cfg_set_t;
endpackage

// File: rtl/synth_level_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer into one clock domain.
// Assumes the input is a slow level; reset value is 0 (inactive).
module synth_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/synth_post_div.sv
`timescale 1ns/1ps
// Even post-divider: q toggles every P source cycles (period 2P), P=0 acts as 1.
// q_half toggles on each rising edge of q (period 4P). hold is a synchronized
// power-down level that clears both outputs and the counter.
module synth_post_div #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] p_val,
    output logic         q,
    output logic         q_half
);
    logic [W-1:0] cnt;
    logic [W-1:0] eff;
    logic         term;

    // Map the reserved zero value onto divide-by-one half period.
    always_comb eff = (p_val == '0) ? W'(1) : p_val;

    // Terminal count of the current half period.
    always_comb term = (cnt >= eff - W'(1));

    // Count source cycles and flip the outputs at each terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt    <= '0;
            q      <= 1'b0;
            q_half <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            q   <= ~q;
            if (!q) q_half <= ~q_half;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    // Counter stays inside the half period once the value is steady.
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(eff) && !hold) |-> (cnt < eff));

    // A held divider comes back cleared.
    p_hold_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0 && !q && !q_half));

    // The half-rate output only moves when q rises.
    p_half_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !$stable(q_half)) |-> $rose(q));
endmodule

// File: rtl/synth_clk_router.sv
`timescale 1ns/1ps
// Clock output router of a programmed synthesizer: selects a configuration set,
// divides reference and VCO clocks, and drives the primary output and the
// multifunction pin. Assumes rst_n is held low across edges of both clocks
// and the cfg_* inputs are static between reconfigurations.
module synth_clk_router
    import synth_clk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk_ref,
    input  logic           clk_vco,
    input  logic           rst_n,
    input  logic [1:0]     cfg_pin_mode,
    input  logic [1:0]     cfg_clk1_src,
    input  logic [P_W-1:0] cfg_a_p,
    input  logic [1:0]     cfg_a_src,
    input  logic [R_W-1:0] cfg_a_r,
    input  logic [M_W-1:0] cfg_a_m,
    input  logic [P_W-1:0] cfg_b_p,
    input  logic [1:0]     cfg_b_src,
    input  logic [R_W-1:0] cfg_b_r,
    input  logic [M_W-1:0] cfg_b_m,
    input  logic           mfp_in,
    output logic           clk0_out,
    output logic           clk0_oe,
    output logic           clk1_out,
    output logic           clk1_oe,
    output logic [R_W-1:0] loop_r_div,
    output logic [M_W-1:0] loop_m_div
);
    localparam logic [P_W-1:0] P_ONE = P_W'(1);

    pin_mode_e mode;
    clk1_src_e src1;
    cfg_set_t  set_a, set_b, set_ref, set_vco;
    logic      selb_raw, pd_raw;
    logic      selb_ref, selb_vco, pd_ref, pd_vco;
    logic      vco_q, vco_qh, refp_q, refp_qh, ref2_q, ref2_unused;
    logic      clk0_int, clk0_half, clk1_int;

    // Gather flat configuration inputs into set records.
    always_comb begin
        mode  = pin_mode_e'(cfg_pin_mode);
        src1  = clk1_src_e'(cfg_clk1_src);
        set_a = '{p: cfg_a_p, src: clk0_src_e'(cfg_a_src), r: cfg_a_r, m: cfg_a_m};
        set_b = '{p: cfg_b_p, src: clk0_src_e'(cfg_b_src), r: cfg_b_r, m: cfg_b_m};
    end

    // Decode the pin level into set-B request and power-down request.
    always_comb begin
        selb_raw = (mode == PIN_SETSEL) && !mfp_in;
        pd_raw   = (mode == PIN_PWRDN)  && !mfp_in;
    end

    synth_level_sync #(.STAGES(SYNC_STAGES)) i_selb_ref (
        .clk(clk_ref), .rst_n(rst_n), .d(selb_raw), .q(selb_ref));
    synth_level_sync #(.STAGES(SYNC_STAGES)) i_selb_vco (
        .clk(clk_vco), .rst_n(rst_n), .d(selb_raw), .q(selb_vco));
    synth_level_sync #(.STAGES(SYNC_STAGES)) i_pd_ref (
        .clk(clk_ref), .rst_n(rst_n), .d(pd_raw), .q(pd_ref));
    synth_level_sync #(.STAGES(SYNC_STAGES)) i_pd_vco (
        .clk(clk_vco), .rst_n(rst_n), .d(pd_raw), .q(pd_vco));

    // Per-domain active set after synchronization.
    always_comb begin
        set_ref = selb_ref ? set_b : set_a;
        set_vco = selb_vco ? set_b : set_a;
    end

    synth_post_div #(.W(P_W)) i_div_vco (
        .clk(clk_vco), .rst_n(rst_n), .hold(pd_vco), .p_val(set_vco.p),
        .q(vco_q), .q_half(vco_qh));
    synth_post_div #(.W(P_W)) i_div_refp (
        .clk(clk_ref), .rst_n(rst_n), .hold(pd_ref), .p_val(set_ref.p),
        .q(refp_q), .q_half(refp_qh));
    synth_post_div #(.W(P_W)) i_div_ref2 (
        .clk(clk_ref), .rst_n(rst_n), .hold(pd_ref), .p_val(P_ONE),
        .q(ref2_q), .q_half(ref2_unused));

    // Primary source and its half-rate companion.
    always_comb begin
        case (set_ref.src)
            SRC0_REF: begin
                clk0_int  = clk_ref & rst_n;
                clk0_half = ref2_q;
            end
            SRC0_REFDIV: begin
                clk0_int  = refp_q;
                clk0_half = refp_qh;
            end
            default: begin
                clk0_int  = vco_q;
                clk0_half = vco_qh;
            end
        endcase
    end

    // Secondary source menu.
    always_comb begin
        case (src1)
            SRC1_REF:   clk1_int = clk_ref & rst_n;
            SRC1_REF2:  clk1_int = ref2_q;
            SRC1_CLK0:  clk1_int = clk0_int;
            default:    clk1_int = clk0_half;
        endcase
    end

    // Output drive and enables.
    always_comb begin
        clk0_out   = clk0_int & ~pd_raw;
        clk0_oe    = !((mode == PIN_ENABLE) && !mfp_in);
        clk1_oe    = (mode == PIN_CLKOUT);
        clk1_out   = (mode == PIN_CLKOUT) & clk1_int;
        loop_r_div = set_ref.r;
        loop_m_div = set_ref.m;
    end

    // Power-down keeps both clocks low.
    p_pd_low_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        pd_raw |-> (!clk0_out && !clk1_out));

    // Secondary clock is idle in the input pin roles.
    p_clk1_idle_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cfg_pin_mode != 2'd3) |-> (!clk1_oe && !clk1_out));

    // Enable-mode low pin turns the primary driver off.
    p_oe_off_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cfg_pin_mode == 2'd0 && !mfp_in) |-> !clk0_oe);

    // Loop values always come from one of the two sets as a pair.
    p_loop_pair_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((loop_r_div == cfg_a_r && loop_m_div == cfg_a_m) ||
         (loop_r_div == cfg_b_r && loop_m_div == cfg_b_m)));

    // Set B is only reached in set-select mode.
    p_seta_only_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(cfg_pin_mode) != 2'd2 && cfg_pin_mode != 2'd2 && !selb_ref)
        |=> !selb_ref);
endmodule

// File: tb/test_synth_clk_router.sv
`timescale 1ns/1ps
module test_synth_clk_router;
    localparam int CLK_PERIOD = 10;   // reference clock, ns
    localparam int VCO_PERIOD = 4;    // VCO clock, ns
    localparam int WD_NS      = 1500000;

    logic        clk_ref = 1'b0, clk_vco = 1'b0, rst_n = 1'b0;
    logic [1:0]  cfg_pin_mode, cfg_clk1_src, cfg_a_src, cfg_b_src;
    logic [4:0]  cfg_a_p, cfg_b_p;
    logic [7:0]  cfg_a_r, cfg_b_r;
    logic [10:0] cfg_a_m, cfg_b_m;
    logic        mfp_in;
    logic        clk0_out, clk0_oe, clk1_out, clk1_oe;
    logic [7:0]  loop_r_div;
    logic [10:0] loop_m_div;

    int tests = 0, fails = 0;
    int mp0, mp1;
    logic meas_sel = 1'b0;
    wire  meas = meas_sel ? clk1_out : clk0_out;

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;
    always #(VCO_PERIOD/2) clk_vco = ~clk_vco;

    synth_clk_router i_synth_clk_router (
        .clk_ref(clk_ref), .clk_vco(clk_vco), .rst_n(rst_n),
        .cfg_pin_mode(cfg_pin_mode), .cfg_clk1_src(cfg_clk1_src),
        .cfg_a_p(cfg_a_p), .cfg_a_src(cfg_a_src), .cfg_a_r(cfg_a_r), .cfg_a_m(cfg_a_m),
        .cfg_b_p(cfg_b_p), .cfg_b_src(cfg_b_src), .cfg_b_r(cfg_b_r), .cfg_b_m(cfg_b_m),
        .mfp_in(mfp_in), .clk0_out(clk0_out), .clk0_oe(clk0_oe),
        .clk1_out(clk1_out), .clk1_oe(clk1_oe),
        .loop_r_div(loop_r_div), .loop_m_div(loop_m_div));

    function automatic int eff_p(input logic [4:0] p);
        return (p == 5'd0) ? 1 : int'(p);
    endfunction

    // Expected primary period from source code and P.
    function automatic int exp_clk0(input logic [1:0] src, input logic [4:0] p);
        case (src)
            2'd1:    return CLK_PERIOD;
            2'd2:    return 2 * eff_p(p) * CLK_PERIOD;
            default: return 2 * eff_p(p) * VCO_PERIOD;
        endcase
    endfunction

    function automatic int exp_clk0_half(input logic [1:0] src, input logic [4:0] p);
        return 2 * exp_clk0(src, p);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Skip settling edges then time two consecutive periods of meas.
    task automatic measure();
        mp0 = -1; mp1 = -1;
        fork
            begin
                time t0, t1, t2;
                repeat (3) @(posedge meas);
                t0 = $time; @(posedge meas);
                t1 = $time; @(posedge meas);
                t2 = $time;
                mp0 = int'(t1 - t0);
                mp1 = int'(t2 - t1);
            end
            begin
                #(30000);
            end
        join_any
        disable fork;
    endtask

    task automatic check_period(input string req, input bit sel, input int exp);
        meas_sel = sel;
        measure();
        check(mp0 == exp && mp1 == exp, req, mp0, exp);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk_ref);
    endtask

    initial begin
        #(WD_NS);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic all_low;
        void'($urandom(32'd4242));
        cfg_pin_mode = 2'd0; cfg_clk1_src = 2'd0; mfp_in = 1'b1;
        cfg_a_p = 5'd3; cfg_a_src = 2'd0; cfg_a_r = 8'h11; cfg_a_m = 11'h123;
        cfg_b_p = 5'd5; cfg_b_src = 2'd2; cfg_b_r = 8'h5a; cfg_b_m = 11'h7e4;

        // R10: reset state
        all_low = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_ref); #1;
            if (clk0_out || clk1_out || clk1_oe) all_low = 1'b0;
        end
        check(all_low, "R10 reset outputs low", int'(all_low), 1);
        @(negedge clk_ref); rst_n = 1'b1;
        settle();

        // R1/R2: loop source with several P values including 0 and 31
        check_period("R1 loop P=3", 1'b0, exp_clk0(2'd0, 5'd3));
        cfg_a_p = 5'd0; settle();
        check_period("R1 P=0 acts as P=1", 1'b0, 2 * VCO_PERIOD);
        cfg_a_p = 5'd1; settle();
        check_period("R1 loop P=1", 1'b0, 2 * VCO_PERIOD);
        cfg_a_p = 5'd31; settle();
        check_period("R1 loop P=31", 1'b0, exp_clk0(2'd0, 5'd31));
        cfg_a_p = 5'd4; cfg_a_src = 2'd1; settle();
        check_period("R2 raw reference", 1'b0, CLK_PERIOD);
        cfg_a_src = 2'd2; settle();
        check_period("R2 reference/2P", 1'b0, 2 * 4 * CLK_PERIOD);
        cfg_a_src = 2'd3; settle();
        check_period("R2 reserved code acts as loop", 1'b0, 2 * 4 * VCO_PERIOD);

        // R4: secondary idle in an input role
        #1;
        check(!clk1_oe, "R4 clk1_oe low in enable mode", int'(clk1_oe), 0);

        // R5: output enable
        mfp_in = 1'b0; #1;
        check(!clk0_oe, "R5 enable pin low", int'(clk0_oe), 0);
        mfp_in = 1'b1; #1;
        check(clk0_oe, "R5 enable pin high", int'(clk0_oe), 1);

        // R3: every secondary source
        cfg_pin_mode = 2'd3; cfg_a_src = 2'd0; cfg_a_p = 5'd2; mfp_in = 1'b0; settle(); #1;
        check(clk1_oe && clk0_oe, "R3 clk1_oe high, clk0_oe high", int'({clk1_oe, clk0_oe}), 3);
        cfg_clk1_src = 2'd0; settle();
        check_period("R3 clk1 reference", 1'b1, CLK_PERIOD);
        cfg_clk1_src = 2'd1; settle();
        check_period("R3 clk1 reference/2", 1'b1, 2 * CLK_PERIOD);
        cfg_clk1_src = 2'd2; settle();
        check_period("R3 clk1 primary", 1'b1, exp_clk0(2'd0, 5'd2));
        cfg_clk1_src = 2'd3; settle();
        check_period("R3 clk1 primary/2", 1'b1, exp_clk0_half(2'd0, 5'd2));
        cfg_a_src = 2'd2; settle();
        check_period("R3 clk1 primary/2 on ref/2P", 1'b1, exp_clk0_half(2'd2, 5'd2));
        cfg_a_src = 2'd1; settle();
        check_period("R3 clk1 primary/2 on raw ref", 1'b1, 2 * CLK_PERIOD);

        // R8: pin low in clock mode keeps set A
        #1;
        check(loop_r_div == cfg_a_r, "R8 clock mode keeps set A", int'(loop_r_div), int'(cfg_a_r));

        // R6: power-down
        cfg_pin_mode = 2'd1; cfg_a_src = 2'd0; cfg_a_p = 5'd3; mfp_in = 1'b1; settle();
        mfp_in = 1'b0;
        all_low = 1'b1;
        for (int i = 0; i < 60; i++) begin
            #7;
            if (clk0_out || clk1_out) all_low = 1'b0;
        end
        check(all_low, "R6 power-down holds outputs low", int'(all_low), 1);
        check(loop_r_div == cfg_a_r, "R8 power-down mode keeps set A", int'(loop_r_div), int'(cfg_a_r));
        mfp_in = 1'b1;
        check_period("R6 period after release", 1'b0, exp_clk0(2'd0, 5'd3));

        // R7/R9: set select
        cfg_pin_mode = 2'd2; mfp_in = 1'b1; settle(); #1;
        check(loop_r_div == cfg_a_r && loop_m_div == cfg_a_m, "R9 set A loop values",
              int'(loop_m_div), int'(cfg_a_m));
        check_period("R7 pin high uses set A", 1'b0, exp_clk0(2'd0, 5'd3));
        mfp_in = 1'b0; settle(); #1;
        check(loop_r_div == cfg_b_r && loop_m_div == cfg_b_m, "R9 set B loop values",
              int'(loop_m_div), int'(cfg_b_m));
        check_period("R7 pin low uses set B", 1'b0, exp_clk0(cfg_b_src, cfg_b_p));

        // R1/R2/R7: random P and source pairs on either set
        for (int i = 0; i < 10; i++) begin
            logic [4:0] rp;
            logic [1:0] rs;
            logic       pin;
            rp  = 5'($urandom % 32);
            rs  = 2'($urandom % 3);
            pin = 1'($urandom % 2);
            if (pin) begin cfg_a_p = rp; cfg_a_src = rs; end
            else     begin cfg_b_p = rp; cfg_b_src = rs; end
            mfp_in = pin;
            settle();
            check_period("R1 R2 R7 random set", 1'b0, exp_clk0(rs, rp));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule